// File: doc/BRIEF.md
# Configurable GPIO Bank with Per-Pin Function Select

This block holds the configuration and data state of one bank of general-purpose pins, up to sixteen of them. Software writes a small function code for every pin through a plain synchronous register port. That code decides whether the pin is a plain input, a driven output, a source for the chip's external interrupt controller, or handed to some other on-chip function. The bank drives an output value and an output enable per pin. It also raises a per-pin flag telling the interrupt logic that the pin has been claimed as an interrupt source.

A parameter picks how the codes are packed. In the first packing each pin gets a 4-bit code in one 32-bit control word. In the second, pins 0..7 use one control word and pins 8 and above use a second one. In the third, each pin has a 2-bit code. The data register moves with the packing. Which code means "interrupt source" is set per bank, and so is the mask of pins that may serve as interrupt sources. A bank with no interrupt capability never raises the flag.

Top module: `gpb_bank`

## Requirements
- R1: After reset every control word and every data latch is zero, so every pin is an input: pad_oe, pad_out and pad_irq_sel are all zero and control reads return 0.
- R2: Register byte offsets depend on the layout. In the two-word 4-bit layout, offset 0x0 holds pins 0..7, offset 0x4 holds pins 8 and up, and the data register is at 0x8. In the other layouts the control word is at 0x0 and the data register is at 0x4. Writes to any other offset change nothing, and reads of any other offset return 0.
- R3: In the 4-bit layouts, the code of pin n (n<8) sits in bits 4n+3..4n of its control word. A pin n>=8 in the two-word layout uses field n-8 of the second word. In the 2-bit layout, pin n uses bits 2n+1..2n. Code 0 means input and code 1 means output. pad_oe[n] is 1 exactly when the code equals 1.
- R4: A data write only updates the latches. pad_out[n] equals latch bit n while the pin is an output and is 0 otherwise. A latch written while the pin is an input appears on the pad once the pin becomes an output.
- R5: Reading the data register returns, in bit n, the latch for output pins and the pad level for all other pins. The pad level goes through a two-flop synchronizer, so a change is seen after the second rising edge and not after the first.
- R6: pad_irq_sel[n] is 1 when the bank has interrupt capability, pin n is allowed by the interrupt mask, and the pin's code equals the bank's interrupt code. The default interrupt code is 0111.
- R7: A pin cleared in the interrupt mask never raises pad_irq_sel, whatever its code. By default, pins 10 and 11 are masked.
- R8: Control words read back exactly as written, all 32 bits, including fields with no pin behind them.
- R9: A code other than input, output or the interrupt code (for example 0010) sets neither pad_oe nor pad_irq_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Byte offset of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pad_in | input | NPINS | Raw pad levels |
| pad_out | output | NPINS | Value driven on each pad |
| pad_oe | output | NPINS | Output enable per pad |
| pad_irq_sel | output | NPINS | Pin routed to the external interrupt |

## Verification
A vector table drives whole-bank patterns: all inputs, all outputs, all interrupt codes, all special codes, a mix of every code across both control words, and a second word carrying bits above the last pin. Together these separate the decode of input, output, interrupt and special codes from each other. They show that the mask cuts only the top pins, and that pin 8 and up take their codes from the second word. Directed tests cover the reset state, a latch written before its pin turns into an output, the two-edge delay of the pad path, and writes to an unmapped offset.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

  typedef enum logic [1:0] {
    GPB_4B_ONE = 2'd0,
    GPB_4B_TWO = 2'd1,
    GPB_2B     = 2'd2
  } gpb_layout_e;

  localparam int unsigned BUS_W = 32;
  localparam logic [3:0] CODE_IN  = 4'b0000;
  localparam logic [3:0] CODE_OUT = 4'b0001;

  // Byte offset of the data register for a layout
  function automatic int unsigned dat_off(gpb_layout_e l);
    return (l == GPB_4B_TWO) ? 8 : 4;
  endfunction

  // Largest pin count a layout can address
  function automatic int unsigned max_pins(gpb_layout_e l);
    return (l == GPB_4B_ONE) ? 8 : 16;
  endfunction

  // Function code of one pin, zero-extended to 4 bits
  function automatic logic [3:0] pick_field(gpb_layout_e l, logic [31:0] c0,
                                            logic [31:0] c1, int unsigned pin);
    logic [31:0] s;
    logic [3:0]  f;
    case (l)
      GPB_2B: begin
        s = c0 >> (2 * pin);
        f = {2'b00, s[1:0]};
      end
      GPB_4B_TWO: begin
        s = (pin >= 8) ? (c1 >> (4 * (pin - 8))) : (c0 >> (4 * pin));
        f = s[3:0];
      end
      default: begin
        s = c0 >> (4 * pin);
        f = s[3:0];
      end
    endcase
    return f;
  endfunction

endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/gpb_regs.sv
module gpb_regs
  import gpb_pkg::*;
#(
  parameter gpb_layout_e LAYOUT = GPB_4B_TWO,
  parameter int unsigned NPINS  = 12,
  parameter int unsigned AW     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             we,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] ctl0_q,
  output logic [BUS_W-1:0] ctl1_q,
  output logic [NPINS-1:0] dat_q,
  output logic             wr_ctl,
  output logic             wr_dat
);
  localparam logic [AW-1:0] A_CTL0 = AW'(0);
  localparam logic [AW-1:0] A_CTL1 = AW'(4);
  localparam logic [AW-1:0] A_DAT  = AW'(dat_off(LAYOUT));
  localparam bit            TWO    = (LAYOUT == GPB_4B_TWO);

  logic hit_ctl0, hit_ctl1;

  assign hit_ctl0 = we && (addr == A_CTL0);
  assign hit_ctl1 = we && TWO && (addr == A_CTL1);
  assign wr_dat   = we && (addr == A_DAT);
  assign wr_ctl   = hit_ctl0 || hit_ctl1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctl0_q <= '0;
    else if (hit_ctl0) ctl0_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dat_q <= '0;
    else if (wr_dat) dat_q <= wdata[NPINS-1:0];
  end

  generate
    if (TWO) begin : g_ctl1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ctl1_q <= '0;
        else if (hit_ctl1) ctl1_q <= wdata;
      end
    end else begin : g_no_ctl1
      assign ctl1_q = '0;
    end
  endgenerate
endmodule

// File: rtl/gpb_pin_ctl.sv
module gpb_pin_ctl
  import gpb_pkg::*;
#(
  parameter gpb_layout_e      LAYOUT   = GPB_4B_TWO,
  parameter int unsigned      NPINS    = 12,
  parameter bit               HAS_IRQ  = 1'b1,
  parameter logic [3:0]       IRQ_CODE = 4'b0111,
  parameter logic [NPINS-1:0] IRQ_MASK = '1
) (
  input  logic [BUS_W-1:0] ctl0,
  input  logic [BUS_W-1:0] ctl1,
  input  logic [NPINS-1:0] dat,
  input  logic [NPINS-1:0] pad_sync,
  output logic [NPINS-1:0] oe,
  output logic [NPINS-1:0] out,
  output logic [NPINS-1:0] irq_sel,
  output logic [NPINS-1:0] rd_dat
);
  generate
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
      logic [3:0] fld;
      assign fld        = pick_field(LAYOUT, ctl0, ctl1, p);
      assign oe[p]      = (fld == CODE_OUT);
      assign out[p]     = oe[p] & dat[p];
      assign irq_sel[p] = HAS_IRQ && IRQ_MASK[p] && (fld == IRQ_CODE);
      assign rd_dat[p]  = oe[p] ? dat[p] : pad_sync[p];
    end
  endgenerate
endmodule

// File: rtl/gpb_bank.sv
module gpb_bank
  import gpb_pkg::*;
#(
  parameter gpb_layout_e      LAYOUT   = GPB_4B_TWO,
  parameter int unsigned      NPINS    = 12,
  parameter int unsigned      AW       = 4,
  parameter bit               HAS_IRQ  = 1'b1,
  parameter logic [3:0]       IRQ_CODE = 4'b0111,
  parameter logic [NPINS-1:0] IRQ_MASK = 12'h3FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_irq_sel
);
  localparam logic [AW-1:0] A_CTL1 = AW'(4);
  localparam logic [AW-1:0] A_DAT  = AW'(dat_off(LAYOUT));
  localparam bit            TWO    = (LAYOUT == GPB_4B_TWO);

  logic [BUS_W-1:0] ctl0_q, ctl1_q;
  logic [NPINS-1:0] dat_q, pad_sync, rd_dat;
  logic             ctl_wr, dat_wr;

  gpb_regs #(.LAYOUT(LAYOUT), .NPINS(NPINS), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .ctl0_q(ctl0_q), .ctl1_q(ctl1_q), .dat_q(dat_q),
    .wr_ctl(ctl_wr), .wr_dat(dat_wr)
  );

  gpb_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync)
  );

  gpb_pin_ctl #(
    .LAYOUT(LAYOUT), .NPINS(NPINS), .HAS_IRQ(HAS_IRQ),
    .IRQ_CODE(IRQ_CODE), .IRQ_MASK(IRQ_MASK)
  ) u_pins (
    .ctl0(ctl0_q), .ctl1(ctl1_q), .dat(dat_q), .pad_sync(pad_sync),
    .oe(pad_oe), .out(pad_out), .irq_sel(pad_irq_sel), .rd_dat(rd_dat)
  );

  always_comb begin
    if (bus_addr == AW'(0))             bus_rdata = ctl0_q;
    else if (TWO && bus_addr == A_CTL1) bus_rdata = ctl1_q;
    else if (bus_addr == A_DAT)         bus_rdata = BUS_W'(rd_dat);
    else                                bus_rdata = '0;
  end
endmodule

// File: rtl/gpb_bank_chk.sv
module gpb_bank_chk #(
  parameter int unsigned      NPINS    = 12,
  parameter int unsigned      AW       = 4,
  parameter logic [NPINS-1:0] IRQ_MASK = '1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      bus_wdata,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_irq_sel,
  input logic             ctl_wr,
  input logic             dat_wr
);
  logic [NPINS-1:0] wlo;
  assign wlo = bus_wdata[NPINS-1:0];

  // R4: pad value only where the pin is an output
  p_out_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);

  // R4: a data write reaches the pads of output pins on the next cycle
  p_dat_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr && !ctl_wr |=> pad_out == ($past(wlo) & pad_oe));

  // R9: output and interrupt routing are exclusive
  p_oe_irq_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_irq_sel) == '0);

  // R7: masked pins never flag an interrupt
  p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_irq_sel & ~IRQ_MASK) == '0);

  // R3: pin roles change only after a control write
  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(pad_oe) && $stable(pad_irq_sel));
endmodule

bind gpb_bank gpb_bank_chk #(.NPINS(NPINS), .AW(AW), .IRQ_MASK(IRQ_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata), .pad_out(pad_out),
  .pad_oe(pad_oe), .pad_irq_sel(pad_irq_sel), .ctl_wr(ctl_wr), .dat_wr(dat_wr)
);

// File: tb/sim_gpb_bank.sv
module sim_gpb_bank;
  localparam int N = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  pad_in = '0;
  logic [N-1:0]  pad_out, pad_oe, pad_irq_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpb_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_irq_sel(pad_irq_sel)
  );

  // {ctl0, ctl1, dat, pad, exp_oe, exp_out, exp_irq}
  localparam logic [123:0] VEC [6] = '{
    {32'h00000000, 32'h00000000, 12'hFFF, 12'h000, 12'h000, 12'h000, 12'h000},
    {32'h11111111, 32'h00001111, 12'hA5A, 12'h000, 12'hFFF, 12'hA5A, 12'h000},
    {32'h77777777, 32'h00007777, 12'hFFF, 12'h0F0, 12'h000, 12'h000, 12'h3FF},
    {32'h22222222, 32'h00002222, 12'hFFF, 12'hFFF, 12'h000, 12'h000, 12'h000},
    {32'h70170271, 32'h00001770, 12'h0F1, 12'hC3C, 12'h821, 12'h021, 12'h292},
    {32'h00000000, 32'hFFFF0001, 12'h100, 12'h0FF, 12'h100, 12'h100, 12'h000}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 oe", 32'(pad_oe), 0);
    chk("R1 out", 32'(pad_out), 0);
    chk("R1 irq", 32'(pad_irq_sel), 0);
    rd(4'h0, r); chk("R1 ctl0", r, 0);
    rd(4'h4, r); chk("R1 ctl1", r, 0);
    rd(4'h8, r); chk("R1 dat", r, 0);

    // Vector table: R3 R6 R7 R8 R9 R5 R4
    for (int i = 0; i < 6; i++) begin
      logic [31:0] c0, c1;
      logic [N-1:0] dv, pv, eo, eu, ei;
      {c0, c1, dv, pv, eo, eu, ei} = VEC[i];
      wr(4'h0, c0);
      wr(4'h4, c1);
      wr(4'h8, 32'(dv));
      pad_in = pv;
      repeat (2) @(negedge clk);
      #1;
      chk($sformatf("R3 oe vec%0d", i), 32'(pad_oe), 32'(eo));
      chk($sformatf("R4 out vec%0d", i), 32'(pad_out), 32'(eu));
      chk($sformatf("R6 R7 R9 irq vec%0d", i), 32'(pad_irq_sel), 32'(ei));
      rd(4'h8, r);
      chk($sformatf("R5 read vec%0d", i), r, 32'((dv & eo) | (pv & ~eo)));
      rd(4'h0, r); chk($sformatf("R8 ctl0 vec%0d", i), r, c0);
      rd(4'h4, r); chk($sformatf("R8 ctl1 vec%0d", i), r, c1);
    end

    // R4: latch written while input, shown once output
    wr(4'h0, 32'h0); wr(4'h4, 32'h0);
    pad_in = '0;
    wr(4'h8, 32'h5A5);
    #1 chk("R4 hidden latch", 32'(pad_out), 0);
    wr(4'h0, 32'h00000011);
    #1 chk("R4 latch on pad", 32'(pad_out), 32'h001);
    chk("R3 oe low pins", 32'(pad_oe), 32'h003);
    repeat (2) @(negedge clk);

    // R5: two-flop delay on the pad path
    @(negedge clk);
    pad_in = 12'hFFE;
    rd(4'h8, r); chk("R5 before edge", r, 32'h001);
    @(negedge clk);
    rd(4'h8, r); chk("R5 one edge", r, 32'h001);
    @(negedge clk);
    rd(4'h8, r); chk("R5 two edges", r, 32'hFFD);

    // R2: unmapped offset
    wr(4'hC, 32'hFFFFFFFF);
    rd(4'hC, r); chk("R2 unmapped read", r, 0);
    rd(4'h0, r); chk("R2 ctl0 kept", r, 32'h00000011);
    rd(4'h4, r); chk("R2 ctl1 kept", r, 0);
    #1 chk("R2 out kept", 32'(pad_out), 32'h001);

    finish_run();
  end
endmodule